// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block generates the column addresses of one SDRAM read or write burst. When a read or write command is accepted, it captures the 9-bit start column together with a mode word. The mode word selects the burst length (1, 2, 4, 8 beats, or an open-ended full-row burst) and the ordering (linear wrap or XOR interleave). From the next cycle on, the block presents one column per valid clock.

A low clock enable suspends the sequence in place. A burst ends in one of three ways: it completes its programmed length, it receives a stop command, or a new read or write takes over. A new command may arrive on every cycle, and each one restarts the sequence from its own column. The memory controller uses the column output, the valid flag and the end-of-burst pulse to drive the array's column decoder. Data timing lies outside this block.

Top module: `burst_col_seq`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, `colValid`, `burstDone` and `colOut` are all 0.
- R2: A clock edge with `clkEn`=1 and `cmdRw`=1 starts a burst. From the next cycle, `colValid`=1 and `colOut` equals the `startCol` sampled at that edge. The length and ordering are captured at the same edge, and later changes to `modeLen` or `modeInterleave` have no effect on that burst.
- R3: `modeLen` values 0, 1, 2 and 3 select bursts of 1, 2, 4 and 8 beats. Any value with bit 2 set selects a full-row burst.
- R4: Linear ordering (`modeInterleave`=0, fixed length BL) gives beat k the start column with its low log2(BL) bits replaced by (start + k) mod BL. The upper bits stay unchanged.
- R5: Interleaved ordering (`modeInterleave`=1, fixed length BL) gives beat k the start column with its low log2(BL) bits XORed with k.
- R6: A full-row burst gives beat k the column (start + k) mod 512. It ignores `modeInterleave` and runs past 512 beats, wrapping, until it is stopped or replaced.
- R7: A cycle with `clkEn`=0 changes neither `colOut`, `colValid` nor the beat position, keeps `burstDone` at 0, and discards `cmdRw` and `cmdStop`.
- R8: On the last beat of a fixed-length burst with `clkEn`=1 and no new command, `burstDone` is 1 for that cycle and `colValid` is 0 from the next cycle. Before that beat, `colValid` stays high.
- R9: `cmdStop` with `clkEn`=1 during an active burst, and with no `cmdRw`, raises `burstDone` in that cycle and ends the burst at that edge. `cmdStop` while idle has no effect.
- R10: `cmdRw` during an active burst restarts the sequence from the new column without asserting `burstDone`. It takes priority over `cmdStop` and over the last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| clkEn | input | 1 | Clock enable; 0 suspends the sequencer |
| cmdRw | input | 1 | Read or write command accepted this cycle |
| cmdStop | input | 1 | Burst stop command this cycle |
| startCol | input | 9 | Start column sampled with `cmdRw` |
| modeLen | input | 3 | Burst length code (0..3 → 1/2/4/8, bit 2 set → full row) |
| modeInterleave | input | 1 | 1 selects XOR ordering for fixed bursts |
| colOut | output | 9 | Current burst column |
| colValid | output | 1 | `colOut` is a live beat |
| burstDone | output | 1 | Burst ends at this clock edge |

## Verification
A behavioural model of beat index and captured mode is compared with the outputs on every cycle. The stimulus covers each length under both orderings, with start columns whose low bits are non-zero and whose upper bits are set; this is what separates linear wrap inside the block from plain counting and from XOR ordering. A full-row burst started near the top of the row runs beyond 512 beats to expose wrap errors. Clock-enable gaps, mode changes mid-burst, commands on every cycle, stop combined with restart, stop while idle, and a long pseudo-random mix check the priority rules and the freeze.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  // Strobes from the control to the address datapath.
  typedef struct packed {
    logic load;     // capture start column and mode, clear beat index
    logic advance;  // step beat index by one
  } colStrobe_t;

endpackage

// File: rtl/burst_col_dp.sv
module burst_col_dp
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9,
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  colStrobe_t       strobe,
  input  logic [COL_W-1:0] startCol,
  input  logic [LEN_W-1:0] modeLen,
  input  logic             modeInterleave,
  output logic [COL_W-1:0] colOut,
  output logic             lastBeat
);

  localparam int EXP_W = LEN_W - 1;

  logic [COL_W-1:0] startReg;
  logic [COL_W-1:0] beatReg;
  logic [LEN_W-1:0] lenReg;
  logic             ilvReg;

  logic             fullPage;
  logic [COL_W-1:0] fixedMask;
  logic [COL_W-1:0] blockMask;
  logic [COL_W-1:0] seqSum;
  logic             useXor;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startReg <= '0;
      beatReg  <= '0;
      lenReg   <= '0;
      ilvReg   <= 1'b0;
    end else if (strobe.load) begin
      startReg <= startCol;
      beatReg  <= '0;
      lenReg   <= modeLen;
      ilvReg   <= modeInterleave;
    end else if (strobe.advance) begin
      beatReg  <= beatReg + COL_W'(1);
    end
  end

  // Top bit of the length code selects the open-ended row burst.
  assign fullPage  = lenReg[LEN_W-1];
  assign fixedMask = (COL_W'(1) << lenReg[EXP_W-1:0]) - COL_W'(1);
  assign blockMask = fullPage ? {COL_W{1'b1}} : fixedMask;
  assign seqSum    = startReg + beatReg;
  assign useXor    = ilvReg & ~fullPage;

  // Bits inside the burst block follow the ordering; bits above stay fixed.
  for (genvar i = 0; i < COL_W; i++) begin : g_colBit
    always_comb begin
      if (!blockMask[i])
        colOut[i] = startReg[i];
      else if (useXor)
        colOut[i] = startReg[i] ^ beatReg[i];
      else
        colOut[i] = seqSum[i];
    end
  end

  assign lastBeat = ~fullPage & (beatReg == fixedMask);

endmodule

// File: rtl/burst_col_ctl.sv
module burst_col_ctl
  import burst_col_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       clkEn,
  input  logic       cmdRw,
  input  logic       cmdStop,
  input  logic       lastBeat,
  output colStrobe_t strobe,
  output logic       colValid,
  output logic       burstDone
);

  logic active;
  logic endNow;

  assign endNow = clkEn & active & ~cmdRw & (cmdStop | lastBeat);

  always_comb begin
    strobe.load    = clkEn & cmdRw;
    strobe.advance = clkEn & active & ~cmdRw & ~endNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      active <= 1'b0;
    else if (strobe.load)
      active <= 1'b1;
    else if (endNow)
      active <= 1'b0;
  end

  assign colValid  = active;
  assign burstDone = endNow;

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9,
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkEn,
  input  logic             cmdRw,
  input  logic             cmdStop,
  input  logic [COL_W-1:0] startCol,
  input  logic [LEN_W-1:0] modeLen,
  input  logic             modeInterleave,
  output logic [COL_W-1:0] colOut,
  output logic             colValid,
  output logic             burstDone
);

  colStrobe_t strobe;
  logic       lastBeat;

  burst_col_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .clkEn     (clkEn),
    .cmdRw     (cmdRw),
    .cmdStop   (cmdStop),
    .lastBeat  (lastBeat),
    .strobe    (strobe),
    .colValid  (colValid),
    .burstDone (burstDone)
  );

  burst_col_dp #(
    .COL_W (COL_W),
    .LEN_W (LEN_W)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .startCol       (startCol),
    .modeLen        (modeLen),
    .modeInterleave (modeInterleave),
    .colOut         (colOut),
    .lastBeat       (lastBeat)
  );

endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic             clkEn,
  input logic             cmdRw,
  input logic             cmdStop,
  input logic [COL_W-1:0] startCol,
  input logic [COL_W-1:0] colOut,
  input logic             colValid,
  input logic             burstDone
);

  assert_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && cmdRw) |=> (colValid && colOut == $past(startCol)));

  assert_freeze_R7: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> ($stable(colOut) && $stable(colValid)));

  assert_nodone_suspend_R7: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |-> !burstDone);

  assert_end_R8: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |=> !colValid);

  assert_done_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |-> colValid);

  assert_hold_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    (colValid && !burstDone) |=> colValid);

  assert_stop_R9: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && cmdStop && colValid && !cmdRw) |-> burstDone);

  assert_restart_R10: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && cmdRw) |-> !burstDone);

endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .clkEn     (clkEn),
  .cmdRw     (cmdRw),
  .cmdStop   (cmdStop),
  .startCol  (startCol),
  .colOut    (colOut),
  .colValid  (colValid),
  .burstDone (burstDone)
);

// File: tb/test_burst_col_seq.sv
`timescale 1ns/1ps
module test_burst_col_seq;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       clkEn = 1'b0;
  logic       cmdRw = 1'b0;
  logic       cmdStop = 1'b0;
  logic [8:0] startCol = '0;
  logic [2:0] modeLen = '0;
  logic       modeInterleave = 1'b0;
  logic [8:0] colOut;
  logic       colValid;
  logic       burstDone;

  int total = 0;
  int bad = 0;

  // reference model state
  bit refActive = 0;
  int refStart = 0;
  int refBeat = 0;
  int refLen = 0;
  bit refIlv = 0;
  bit refFull = 0;

  always #4 clk = ~clk;

  burst_col_seq i_burst_col_seq (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .cmdRw(cmdRw), .cmdStop(cmdStop),
    .startCol(startCol), .modeLen(modeLen), .modeInterleave(modeInterleave),
    .colOut(colOut), .colValid(colValid), .burstDone(burstDone)
  );

  function automatic int expCol();
    int bl, lo;
    if (refFull) return (refStart + refBeat) % 512;
    bl = 1 << refLen;
    lo = refStart % bl;
    if (refIlv) return (refStart - lo) + (lo ^ refBeat);
    return (refStart - lo) + ((lo + refBeat) % bl);
  endfunction

  task automatic cyc(input string req, input bit ce, input bit rw, input bit stp,
                     input int col, input int len, input bit ilv);
    bit expDone;
    int expC;
    @(negedge clk);
    clkEn = ce; cmdRw = rw; cmdStop = stp;
    startCol = 9'(col); modeLen = 3'(len); modeInterleave = ilv;
    #1;
    expDone = ce && refActive && !rw && (stp || (!refFull && refBeat == (1 << refLen) - 1));
    expC = expCol();
    total++;
    if (colValid !== refActive) begin
      bad++;
      $display("FAIL %s colValid actual=%0b expected=%0b", req, colValid, refActive);
    end else if (burstDone !== expDone) begin
      bad++;
      $display("FAIL %s burstDone actual=%0b expected=%0b", req, burstDone, expDone);
    end else if (refActive && int'(colOut) != expC) begin
      bad++;
      $display("FAIL %s colOut actual=%0h expected=%0h", req, colOut, expC);
    end
    // model update for the coming edge
    if (ce) begin
      if (rw) begin
        refActive = 1; refStart = col; refBeat = 0;
        refFull = len[2]; refLen = len & 3; refIlv = ilv;
      end else if (refActive) begin
        if (expDone) refActive = 0;
        else refBeat = (refBeat + 1) % 512;
      end
    end
  endtask

  task automatic idle(input string req, input int n);
    for (int i = 0; i < n; i++) cyc(req, 1, 0, 0, 0, 0, 0);
  endtask

  task automatic burst(input string req, input int col, input int len, input bit ilv, input int beats);
    cyc(req, 1, 1, 0, col, len, ilv);
    for (int i = 0; i < beats; i++) cyc(req, 1, 0, 0, 0, 0, 0);
  endtask

  initial begin
    int lfsr;
    // R1: reset values
    repeat (3) begin
      @(negedge clk);
      total++;
      if (colValid !== 1'b0 || burstDone !== 1'b0 || colOut !== 9'h0) begin
        bad++;
        $display("FAIL R1 reset actual=%0b/%0b/%0h expected=0/0/0", colValid, burstDone, colOut);
      end
    end
    rstN = 1'b1;
    idle("R1", 2);

    // R4: linear ordering, several lengths, non-aligned starts
    burst("R4", 9'h1FD, 3, 0, 9);
    burst("R4", 9'h0A6, 2, 0, 5);
    burst("R4", 9'h155, 1, 0, 3);
    // R5: XOR ordering
    burst("R5", 9'h135, 3, 1, 9);
    burst("R5", 9'h0F6, 2, 1, 5);
    burst("R5", 9'h0C3, 1, 1, 3);
    // R3: single beat and code mapping
    burst("R3", 9'h07F, 0, 0, 2);
    burst("R3", 9'h07F, 0, 1, 2);
    // R6: full row, wraps past 512 beats, ordering ignored, then stop (R9)
    burst("R6", 9'h1FE, 7, 1, 520);
    cyc("R9", 1, 0, 1, 0, 0, 0);
    idle("R9", 2);
    burst("R6", 9'h010, 4, 0, 20);
    cyc("R9", 1, 0, 1, 0, 0, 0);
    // R7: clock enable gaps during a burst
    cyc("R7", 1, 1, 0, 9'h12B, 3, 0);
    for (int i = 0; i < 16; i++) cyc("R7", i % 3 != 0, i == 5, i == 7, 9'h1FF, 0, 1);
    idle("R7", 10);
    // R2: mode inputs change mid-burst
    cyc("R2", 1, 1, 0, 9'h033, 2, 1);
    for (int i = 0; i < 5; i++) cyc("R2", 1, 0, 0, 9'h1AA, 7 - i, i % 2);
    // R10: a command on every cycle, with stop and last beat collisions
    for (int i = 0; i < 12; i++) cyc("R10", 1, 1, i % 2, 9'h040 + i * 37, i % 5, i % 2);
    cyc("R10", 1, 1, 0, 9'h101, 1, 0);
    cyc("R10", 1, 0, 0, 0, 0, 0);
    cyc("R10", 1, 1, 0, 9'h102, 0, 0);
    idle("R10", 2);
    // R9: stop in a fixed burst, stop while idle
    burst("R9", 9'h0E0, 3, 0, 3);
    cyc("R9", 1, 0, 1, 0, 0, 0);
    cyc("R9", 1, 0, 1, 0, 0, 0);
    idle("R9", 2);
    // R8: completion of each fixed length
    for (int l = 0; l < 4; l++) burst("R8", 9'h1E7, l, l % 2, (1 << l) + 1);
    // mixed pseudo-random traffic
    lfsr = 32'h1D2C3B4A;
    for (int i = 0; i < 3000; i++) begin
      lfsr = lfsr[31] ? ((lfsr << 1) ^ 32'h04C11DB7) : (lfsr << 1);
      cyc("R8", lfsr[3:0] != 0, lfsr[8:4] == 0, lfsr[13:9] == 0,
          lfsr[22:14], lfsr[25:23], lfsr[26]);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule